// File: doc/BRIEF.md
# Manchester FSK/OOK Modulator Control

This block sits between a serial stream of data bits and the control pins of a radio transmitter. Each bit offered on a ready/valid handshake is Manchester-coded into two half-bit symbols. Each symbol is then turned into transmitter controls for one of two modulation schemes. In frequency-shift mode the symbol picks between the nominal (all-zero) varactor code and a programmed deviation code for a binary-weighted varactor bank. In on-off mode the symbol gates the power amplifier enable. A separate power-level code is passed to the amplifier's drive-strength pins.

Half-bit timing comes from an external strobe, `half_tick`, one pulse per half-bit period. The mode, deviation code and power code are sampled only on the strobe that opens a new bit period. A setting changed while a bit is being sent therefore never splits that bit. When no bit is waiting at a boundary, the block goes idle and sends the mark-free state of the current mode.

Top module: `manchester_mod`

## Requirements
- R1: After reset `dev_code` is 0, `pa_on` is 1 (frequency-shift mode), `pa_level` is 0 and `in_ready` is 0 while `half_tick` is low.
- R2: `in_ready` is 1 only in a cycle where `half_tick` is 1 and the block is idle or in the second half of a bit. On the strobe that ends a first half it is 0, and `in_valid`/`in_data` are then ignored.
- R3: A bit is taken when `in_valid` and `in_ready` are both 1 at a clock edge. A 1 is sent as a high symbol then a low symbol, and a 0 as low then high. Each half starts at the edge after its strobe.
- R4: With `cfg_ook` = 0 (frequency-shift), a high symbol drives `dev_code` to the latched deviation code, and a low symbol drives it to 0. `pa_on` stays 1.
- R5: With `cfg_ook` = 1 (on-off), a high symbol drives `pa_on` to 1 and a low symbol drives it to 0. `dev_code` stays 0.
- R6: While idle, `dev_code` is 0 in both modes. `pa_on` is 1 in frequency-shift mode and 0 in on-off mode.
- R7: `pa_level` equals the `cfg_pwr` value latched at the most recent bit-boundary strobe.
- R8: `cfg_ook`, `cfg_dev` and `cfg_pwr` are latched only at a bit-boundary strobe. A change applied during a bit does not alter that bit's second half.
- R9: A bit offered at the strobe ending the previous bit's second half follows it with no idle half in between.
- R10: Outputs change only at the edge that follows a `half_tick` strobe. In all other cycles they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_tick | input | 1 | One-cycle strobe per half-bit period |
| in_valid | input | 1 | A data bit is offered |
| in_data | input | 1 | The offered data bit |
| in_ready | output | 1 | The offered bit is taken at this edge |
| cfg_ook | input | 1 | 0 = frequency-shift, 1 = on-off keying |
| cfg_dev | input | DEV_W | Deviation code for a high symbol |
| cfg_pwr | input | PWR_W | Amplifier power code |
| dev_code | output | DEV_W | Varactor bank code |
| pa_on | output | 1 | Amplifier cascode enable |
| pa_level | output | PWR_W | Latched amplifier power code |

## Verification
The assertions assume `half_tick` is a single-cycle pulse. They also assume configuration is only meaningful at bit-boundary strobes. The stimulus therefore raises the strobe for exactly one cycle, followed by quiet cycles. It changes the configuration between strobes, including once inside a bit, to test the latching rule. Offered data during a mid-bit strobe is deliberately the inverse of the real bit, so that any wrong acceptance shows up in the later symbols.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } phase_e;

    typedef enum logic {
        MODE_FSK = 1'b0,
        MODE_OOK = 1'b1
    } mod_mode_e;

endpackage

// File: rtl/mtx_seq.sv
// Half-bit sequencer: accepts a bit at a boundary strobe, emits the
// Manchester symbol for each half.
module mtx_seq
    import mtx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic half_tick,
    input  logic in_valid,
    input  logic in_data,
    output logic in_ready,
    output logic load_cfg,
    output logic busy,
    output logic sym
);

    typedef struct packed {
        phase_e phase;
        logic   bit_v;
    } seq_t;

    seq_t seq_q, seq_d;
    logic at_boundary;

    always_comb begin
        seq_d       = seq_q;
        at_boundary = (seq_q.phase != PH_FIRST);
        in_ready    = half_tick && at_boundary;
        load_cfg    = in_ready;
        if (half_tick) begin
            if (!at_boundary) begin
                seq_d.phase = PH_SECOND;
            end else if (in_valid) begin
                seq_d.phase = PH_FIRST;
                seq_d.bit_v = in_data;
            end else begin
                seq_d.phase = PH_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{phase: PH_IDLE, bit_v: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy = (seq_q.phase != PH_IDLE);
    assign sym  = (seq_q.phase == PH_FIRST) ? seq_q.bit_v : ~seq_q.bit_v;

endmodule

// File: rtl/mtx_cfg_hold.sv
// Shadow of the configuration, refreshed only at bit boundaries.
module mtx_cfg_hold
    import mtx_pkg::*;
#(
    parameter int DEV_W = 3,
    parameter int PWR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  mod_mode_e        mode_in,
    input  logic [DEV_W-1:0] dev_in,
    input  logic [PWR_W-1:0] pwr_in,
    output mod_mode_e        mode_out,
    output logic [DEV_W-1:0] dev_out,
    output logic [PWR_W-1:0] pwr_out
);

    typedef struct packed {
        mod_mode_e        mode;
        logic [DEV_W-1:0] dev;
        logic [PWR_W-1:0] pwr;
    } cfg_t;

    cfg_t cfg_q, cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (load) begin
            cfg_d.mode = mode_in;
            cfg_d.dev  = dev_in;
            cfg_d.pwr  = pwr_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{mode: MODE_FSK, dev: '0, pwr: '0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mode_out = cfg_q.mode;
    assign dev_out  = cfg_q.dev;
    assign pwr_out  = cfg_q.pwr;

endmodule

// File: rtl/mtx_map.sv
// Maps the current symbol onto the transmitter controls of the active mode.
module mtx_map
    import mtx_pkg::*;
#(
    parameter int DEV_W = 3,
    parameter int PWR_W = 4
) (
    input  mod_mode_e        mode,
    input  logic [DEV_W-1:0] dev,
    input  logic [PWR_W-1:0] pwr,
    input  logic             busy,
    input  logic             sym,
    output logic [DEV_W-1:0] dev_code,
    output logic             pa_on,
    output logic [PWR_W-1:0] pa_level
);

    logic mark;

    always_comb begin
        mark     = busy && sym;
        pa_level = pwr;
        unique case (mode)
            MODE_OOK: begin
                dev_code = '0;
                pa_on    = mark;
            end
            default: begin
                dev_code = mark ? dev : '0;
                pa_on    = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/manchester_mod.sv
module manchester_mod
    import mtx_pkg::*;
#(
    parameter int DEV_W = 3,
    parameter int PWR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             half_tick,
    input  logic             in_valid,
    input  logic             in_data,
    output logic             in_ready,
    input  logic             cfg_ook,
    input  logic [DEV_W-1:0] cfg_dev,
    input  logic [PWR_W-1:0] cfg_pwr,
    output logic [DEV_W-1:0] dev_code,
    output logic             pa_on,
    output logic [PWR_W-1:0] pa_level
);

    logic             seq_load;
    logic             seq_busy;
    logic             seq_sym;
    mod_mode_e        act_mode;
    logic [DEV_W-1:0] act_dev;
    logic [PWR_W-1:0] act_pwr;

    mtx_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_tick(half_tick),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .load_cfg (seq_load),
        .busy     (seq_busy),
        .sym      (seq_sym)
    );

    mtx_cfg_hold #(.DEV_W(DEV_W), .PWR_W(PWR_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (seq_load),
        .mode_in (mod_mode_e'(cfg_ook)),
        .dev_in  (cfg_dev),
        .pwr_in  (cfg_pwr),
        .mode_out(act_mode),
        .dev_out (act_dev),
        .pwr_out (act_pwr)
    );

    mtx_map #(.DEV_W(DEV_W), .PWR_W(PWR_W)) u_map (
        .mode    (act_mode),
        .dev     (act_dev),
        .pwr     (act_pwr),
        .busy    (seq_busy),
        .sym     (seq_sym),
        .dev_code(dev_code),
        .pa_on   (pa_on),
        .pa_level(pa_level)
    );

endmodule

// File: rtl/mtx_checker.sv
module mtx_checker #(
    parameter int DEV_W = 3,
    parameter int PWR_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             half_tick,
    input logic             in_ready,
    input logic             seq_busy,
    input logic             seq_sym,
    input logic [DEV_W-1:0] dev_code,
    input logic             pa_on,
    input logic [PWR_W-1:0] pa_level
);

    // R2: acceptance only on a strobe
    p_ready_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> half_tick);

    // R3: a mid-bit strobe inverts the symbol
    p_manchester_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (half_tick && !in_ready) |=> (seq_sym == !$past(seq_sym)));

    // R6: idle drives the nominal varactor code
    p_idle_nominal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_busy |-> (dev_code == '0));

    // R4: a nonzero deviation code only while the amplifier runs
    p_dev_needs_pa_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_code != '0) |-> pa_on);

    // R8: power code moves only at a boundary strobe
    p_cfg_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> $stable(pa_level));

    // R10: no strobe, no output change
    p_hold_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !half_tick |=> ($stable(dev_code) && $stable(pa_on)));

endmodule

bind manchester_mod mtx_checker #(.DEV_W(DEV_W), .PWR_W(PWR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .half_tick(half_tick),
    .in_ready (in_ready),
    .seq_busy (seq_busy),
    .seq_sym  (seq_sym),
    .dev_code (dev_code),
    .pa_on    (pa_on),
    .pa_level (pa_level)
);

// File: tb/manchester_mod_tb.sv
module manchester_mod_tb;

    localparam int DEV_W = 3;
    localparam int PWR_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             half_tick = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_data = 1'b0;
    logic             in_ready;
    logic             cfg_ook = 1'b0;
    logic [DEV_W-1:0] cfg_dev = '0;
    logic [PWR_W-1:0] cfg_pwr = '0;
    logic [DEV_W-1:0] dev_code;
    logic             pa_on;
    logic [PWR_W-1:0] pa_level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    manchester_mod #(.DEV_W(DEV_W), .PWR_W(PWR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .cfg_ook(cfg_ook), .cfg_dev(cfg_dev), .cfg_pwr(cfg_pwr),
        .dev_code(dev_code), .pa_on(pa_on), .pa_level(pa_level)
    );

    // reference state built from the requirements: 0 idle, 1 first, 2 second
    int               m_phase = 0;
    logic             m_bit = 1'b0;
    logic             m_ook = 1'b0;
    logic [DEV_W-1:0] m_dev = '0;
    logic [PWR_W-1:0] m_pwr = '0;

    typedef struct {
        logic [DEV_W-1:0] dev;
        logic             pa;
        logic [PWR_W-1:0] lvl;
        string            tag;
    } exp_t;

    exp_t exp_q[$];
    event sample_ev;

    task automatic check1(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver side: push expectation for the current cycle
    task automatic push_expect(input string tag);
        exp_t e;
        logic high;
        high = (m_phase != 0) && ((m_phase == 1) ? m_bit : ~m_bit);
        if (m_ook) begin
            e.dev = '0;
            e.pa  = high;
        end else begin
            e.dev = high ? m_dev : '0;
            e.pa  = 1'b1;
        end
        e.lvl = m_pwr;
        e.tag = tag;
        exp_q.push_back(e);
        -> sample_ev;
        #1;
    endtask

    // monitor side
    initial begin
        forever begin
            @(sample_ev);
            if (exp_q.size() != 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check1(dev_code, e.dev, {e.tag, " dev_code"});
                check1(pa_on, e.pa, {e.tag, " pa_on"});
                check1(pa_level, e.lvl, {e.tag, " pa_level"});
            end
        end
    end

    task automatic tick(input logic v, input logic d, input string tag);
        @(negedge clk);
        half_tick = 1'b1;
        in_valid  = v;
        in_data   = d;
        #1;
        check1(in_ready, (m_phase != 1), {tag, " R2 in_ready"});
        if (m_phase != 1) begin
            m_ook = cfg_ook;
            m_dev = cfg_dev;
            m_pwr = cfg_pwr;
            if (v) begin
                m_phase = 1;
                m_bit   = d;
            end else begin
                m_phase = 0;
            end
        end else begin
            m_phase = 2;
        end
        @(posedge clk);
        @(negedge clk);
        half_tick = 1'b0;
        in_valid  = 1'b0;
        push_expect(tag);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            push_expect({tag, " R10 hold"});
        end
    endtask

    // one bit: boundary strobe with the bit, mid strobe offering the inverse
    task automatic send_bit(input logic b, input string tag);
        tick(1'b1, b, {tag, " first"});
        tick(1'b1, ~b, {tag, " second"});
    endtask

    initial begin
        cfg_dev = 3'd5;
        cfg_pwr = 4'd9;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check1(in_ready, 0, "R1 in_ready");
        push_expect("R1 reset");

        tick(1'b0, 1'b0, "R7 R6 idle fsk");
        send_bit(1'b1, "R3 R4 R9");
        send_bit(1'b0, "R3 R4 R9");
        send_bit(1'b1, "R3 R4 R9");
        send_bit(1'b1, "R3 R4 R9");
        tick(1'b0, 1'b0, "R6 idle after");

        tick(1'b1, 1'b1, "R8 start");
        @(negedge clk);
        cfg_ook = 1'b1;
        cfg_dev = 3'd2;
        cfg_pwr = 4'd3;
        tick(1'b0, 1'b0, "R8 mid keeps old cfg");

        send_bit(1'b0, "R5 R8 ook");
        send_bit(1'b1, "R5 ook");
        tick(1'b0, 1'b0, "R6 idle ook");

        @(negedge clk);
        cfg_ook = 1'b0;
        cfg_dev = 3'd7;
        cfg_pwr = 4'd15;
        tick(1'b0, 1'b0, "R7 level max");
        send_bit(1'b1, "R4 dev max");
        send_bit(1'b0, "R4 dev max");
        tick(1'b0, 1'b0, "R6 idle end");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule